// File: doc/BRIEF.md
# Two-Level Overcurrent and Fault Sequencer

This block supervises a resonant half-bridge controller. It takes the digital outputs of the analog comparators and decides, cycle by cycle, whether the gates may switch. It also decides whether the soft-start capacitor is shorted, whether the protection timer capacitor is charged, and whether the controller is latched off. The comparators cover the current-sense levels, the timer capacitor levels, line voltage, supply voltage, temperature, external shutdown and light-load feedback. Every comparator bit is resynchronised before use. Each hysteresis pair arrives as two separate bits, one that sets a condition and one that clears it.

Overcurrent escalates in stages. A moderate overcurrent shorts the soft-start capacitor for a guaranteed minimum time and charges the timer. If the timer then reaches its middle level, the soft start is held fully discharged, which forces maximum frequency. If it reaches its top level, the block latches off. A severe overcurrent latches off at once. After an overcurrent latch, the block leaves the latch only when the supply has dropped below undervoltage while latched and the timer has decayed. After an external latch, the supply drop alone is enough. Every restart passes through soft start, except a wake-up from light-load burst idle.

Top module: `ocp_fault_seq`

## Requirements
- R1: From SOFTSTART or RUN, a high current-regulation bit moves the block to OCR. In OCR the gates stay enabled, the soft-start discharge is on, and the timer charge is on. OCR is held for at least HOLD_CYCLES cycles after entry, even if the bit falls sooner.
- R2: In OCR, the block returns to RUN once the current-regulation bit is low, the hold time has elapsed and the timer middle-level bit is low. In RUN, the discharge and the timer charge are both off.
- R3: In OCR, a high timer middle-level bit moves the block to FMAX, where the discharge, the timer charge and the gates are all on. If the current-regulation bit falls while in FMAX, the block returns to SOFTSTART.
- R4: In FMAX, a high timer top-level bit moves the block to LATCHED. In LATCHED the gates are off, the timer charge is off, the discharge is on and the latched-off output is 1.
- R5: In any switching state (SOFTSTART, RUN, OCR, FMAX, BURST), a high current-trip bit moves the block to LATCHED on the next state update.
- R6: An overcurrent latch is left for OFF only after the supply undervoltage bit has been seen while latched and the timer low-level bit is high; neither condition alone is enough. From OFF, switching resumes only after the supply start bit has set the supply-good flag again.
- R7: A high external-latch bit moves the block to LATCHED from OFF (with the supply good) or from any switching state. That latch is released by a supply undervoltage alone, whatever the timer bit.
- R8: The line-on bit sets the line-good flag and the line-off bit clears it; when both are low the flag keeps its value. A cleared line-good flag or a high line-overvoltage bit forces OFF, where the gates are off and the discharge is on.
- R9: In RUN, the burst-low bit moves the block to BURST, where the gates are off and the discharge is off. The burst-high bit returns it directly to RUN, with no soft start.
- R10: Supply undervoltage or over-temperature forces OFF from any switching state. Clearing the fault restarts through SOFTSTART.
- R11: SOFTSTART lasts SS_CYCLES cycles with the gates enabled and the discharge off, then moves to RUN.
- R12: The state output uses this encoding: OFF=0, SOFTSTART=1, RUN=2, OCR=3, FMAX=4, BURST=5, LATCHED=6. Reset leaves the block in OFF.
- R13: When several conditions arrive in the same cycle, supply undervoltage takes priority over every latch request, and a latch request takes priority over line and temperature faults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csRegHi | input | 1 | Current sense above regulation level |
| csTripHi | input | 1 | Current sense above trip level |
| tmrMidHi | input | 1 | Timer above forced-frequency level |
| tmrTopHi | input | 1 | Timer above shutdown level |
| tmrLowLo | input | 1 | Timer below restart level |
| lineOnHi | input | 1 | Line sense above turn-on level |
| lineOffLo | input | 1 | Line sense below turn-off level |
| lineOvHi | input | 1 | Line sense above clamp level |
| vccStartHi | input | 1 | Supply above start threshold |
| vccUvLo | input | 1 | Supply below undervoltage threshold |
| overTempHi | input | 1 | Over-temperature flag |
| extLatchHi | input | 1 | External latch input above threshold |
| burstLowLo | input | 1 | Feedback below burst entry level |
| burstHighHi | input | 1 | Feedback above burst exit level |
| ssDischarge | output | 1 | Soft-start discharge switch on |
| timerCharge | output | 1 | Timer charge source on |
| gateEn | output | 1 | Half-bridge gates allowed to switch |
| latchedOff | output | 1 | Controller latched off |
| fsmState | output | 3 | Current state code |

## Verification
A severe overcurrent and a line fault can arrive in the same cycle. So can a supply undervoltage and a severe overcurrent. The bench raises each pair on the same clock edge, so both bits clear the synchronizer together. It then checks that the first pair ends in LATCHED and the second in OFF, which confirms the priority order. It also sets the timer-low and supply-undervoltage conditions one at a time, and checks that the latch holds until both are present.

// File: rtl/ocp_seq_pkg.sv
package ocp_seq_pkg;

  typedef enum logic [2:0] {
    ST_OFF       = 3'd0,
    ST_SOFTSTART = 3'd1,
    ST_RUN       = 3'd2,
    ST_OCR       = 3'd3,
    ST_FMAX      = 3'd4,
    ST_BURST     = 3'd5,
    ST_LATCHED   = 3'd6
  } seqState_t;

  localparam int NUM_IN   = 14;
  localparam int I_CSREG  = 0;
  localparam int I_CSTRIP = 1;
  localparam int I_TMID   = 2;
  localparam int I_TTOP   = 3;
  localparam int I_TLOW   = 4;
  localparam int I_LON    = 5;
  localparam int I_LOFF   = 6;
  localparam int I_LOV    = 7;
  localparam int I_VSTART = 8;
  localparam int I_VUV    = 9;
  localparam int I_OT     = 10;
  localparam int I_EXT    = 11;
  localparam int I_BLOW   = 12;
  localparam int I_BHIGH  = 13;

  typedef struct packed {
    logic holdLoad;
    logic ssLoad;
    logic latchArm;
    logic latchExt;
  } ctrlStrobe_t;

  typedef struct packed {
    logic powerOk;
    logic lineOk;
    logic burstIdle;
    logic holdDone;
    logic ssDone;
    logic relUv;
    logic extCause;
    logic csReg;
    logic csTrip;
    logic tmrMid;
    logic tmrTop;
    logic tmrLow;
    logic lineOv;
    logic overTemp;
    logic extLatch;
  } dpStatus_t;

endpackage

// File: rtl/ocp_sync_bits.sv
module ocp_sync_bits #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], asyncIn[b]};
    end
    assign syncOut[b] = chain[STAGES-1];
  end
endmodule

// File: rtl/ocp_seq_dp.sv
module ocp_seq_dp
  import ocp_seq_pkg::*;
#(
  parameter int HOLD_CYCLES = 20,
  parameter int SS_CYCLES   = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_IN-1:0] syn,
  input  ctrlStrobe_t       strobe,
  output dpStatus_t         status
);
  localparam int HW = $clog2(HOLD_CYCLES + 1);
  localparam int SW = $clog2(SS_CYCLES + 1);

  logic [HW-1:0] holdCnt;
  logic [SW-1:0] ssCnt;
  logic powerReg, lineReg, idleReg, relUvReg, extCauseReg;
  logic powerNow, lineNow, idleNow;

  // Hysteresis flags: clear bit wins, set bit or held value otherwise
  assign powerNow = !syn[I_VUV]   && (syn[I_VSTART] || powerReg);
  assign lineNow  = !syn[I_LOFF]  && (syn[I_LON]    || lineReg);
  assign idleNow  = !syn[I_BHIGH] && (syn[I_BLOW]   || idleReg);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      powerReg    <= 1'b0;
      lineReg     <= 1'b0;
      idleReg     <= 1'b0;
      relUvReg    <= 1'b0;
      extCauseReg <= 1'b0;
      holdCnt     <= '0;
      ssCnt       <= '0;
    end else begin
      powerReg <= powerNow;
      lineReg  <= lineNow;
      idleReg  <= idleNow;
      if (strobe.holdLoad)   holdCnt <= HW'(HOLD_CYCLES);
      else if (holdCnt != 0) holdCnt <= holdCnt - 1'b1;
      if (strobe.ssLoad)     ssCnt <= SW'(SS_CYCLES);
      else if (ssCnt != 0)   ssCnt <= ssCnt - 1'b1;
      if (strobe.latchArm) begin
        relUvReg    <= 1'b0;
        extCauseReg <= strobe.latchExt;
      end else if (syn[I_VUV]) begin
        relUvReg <= 1'b1;
      end
    end
  end

  always_comb begin
    status.powerOk   = powerNow;
    status.lineOk    = lineNow;
    status.burstIdle = idleNow;
    status.holdDone  = (holdCnt == 0);
    status.ssDone    = (ssCnt == 0);
    status.relUv     = relUvReg;
    status.extCause  = extCauseReg;
    status.csReg     = syn[I_CSREG];
    status.csTrip    = syn[I_CSTRIP];
    status.tmrMid    = syn[I_TMID];
    status.tmrTop    = syn[I_TTOP];
    status.tmrLow    = syn[I_TLOW];
    status.lineOv    = syn[I_LOV];
    status.overTemp  = syn[I_OT];
    status.extLatch  = syn[I_EXT];
  end

  AST_HOLD_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.holdLoad |=> (holdCnt == HW'(HOLD_CYCLES))); // R1
  AST_REL_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.latchArm |=> !relUvReg); // R6
  AST_SS_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.ssLoad |=> (ssCnt == SW'(SS_CYCLES))); // R11
endmodule

// File: rtl/ocp_seq_ctrl.sv
module ocp_seq_ctrl
  import ocp_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  dpStatus_t   status,
  output ctrlStrobe_t strobe,
  output seqState_t   state,
  output logic        ssDischarge,
  output logic        timerCharge,
  output logic        gateEn,
  output logic        latchedOff
);
  seqState_t nextState;
  logic latchReq, offReq;

  always_comb begin
    nextState = state;
    strobe    = '0;
    latchReq  = status.csTrip || status.extLatch ||
                (state == ST_FMAX && status.tmrTop);
    offReq    = !status.lineOk || status.lineOv || status.overTemp;
    case (state)
      ST_OFF: begin
        if (status.powerOk) begin
          if (status.extLatch) nextState = ST_LATCHED;
          else if (!offReq)    nextState = ST_SOFTSTART;
        end
      end
      ST_LATCHED: begin
        if (status.relUv && (status.extCause || status.tmrLow)) nextState = ST_OFF;
      end
      default: begin
        if (!status.powerOk)  nextState = ST_OFF;
        else if (latchReq)    nextState = ST_LATCHED;
        else if (offReq)      nextState = ST_OFF;
        else begin
          case (state)
            ST_SOFTSTART: begin
              if (status.csReg)       nextState = ST_OCR;
              else if (status.ssDone) nextState = ST_RUN;
            end
            ST_RUN: begin
              if (status.csReg)          nextState = ST_OCR;
              else if (status.burstIdle) nextState = ST_BURST;
            end
            ST_OCR: begin
              if (status.tmrMid)                            nextState = ST_FMAX;
              else if (!status.csReg && status.holdDone)    nextState = ST_RUN;
            end
            ST_FMAX:  if (!status.csReg)     nextState = ST_SOFTSTART;
            ST_BURST: if (!status.burstIdle) nextState = ST_RUN;
            default:  nextState = ST_OFF;
          endcase
        end
      end
    endcase
    if (nextState == ST_SOFTSTART && state != ST_SOFTSTART) strobe.ssLoad = 1'b1;
    if (nextState == ST_OCR && state != ST_OCR)             strobe.holdLoad = 1'b1;
    if (nextState == ST_LATCHED && state != ST_LATCHED) begin
      strobe.latchArm = 1'b1;
      strobe.latchExt = status.extLatch;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_OFF;
    else        state <= nextState;
  end

  always_comb begin
    gateEn      = state inside {ST_SOFTSTART, ST_RUN, ST_OCR, ST_FMAX};
    ssDischarge = state inside {ST_OFF, ST_OCR, ST_FMAX, ST_LATCHED};
    timerCharge = state inside {ST_OCR, ST_FMAX};
    latchedOff  = (state == ST_LATCHED);
  end

  AST_OCR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_OCR && !status.holdDone) |=> (state != ST_RUN)); // R1
  AST_TOP_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FMAX && status.tmrTop && status.powerOk) |=> (state == ST_LATCHED)); // R4
  AST_TRIP_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    (state inside {ST_SOFTSTART, ST_RUN, ST_OCR, ST_FMAX, ST_BURST} &&
     status.csTrip && status.powerOk) |=> (state == ST_LATCHED)); // R5
  AST_LATCH_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_LATCHED && !status.relUv) |=> (state == ST_LATCHED)); // R6
  AST_BURST_NO_SS: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_BURST) |=> (state != ST_SOFTSTART)); // R9
  AST_UV_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (state inside {ST_SOFTSTART, ST_RUN, ST_OCR, ST_FMAX, ST_BURST} && !status.powerOk)
    |=> (state == ST_OFF)); // R13
endmodule

// File: rtl/ocp_fault_seq.sv
module ocp_fault_seq
  import ocp_seq_pkg::*;
#(
  parameter int HOLD_CYCLES = 20,
  parameter int SS_CYCLES   = 40,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       csRegHi,
  input  logic       csTripHi,
  input  logic       tmrMidHi,
  input  logic       tmrTopHi,
  input  logic       tmrLowLo,
  input  logic       lineOnHi,
  input  logic       lineOffLo,
  input  logic       lineOvHi,
  input  logic       vccStartHi,
  input  logic       vccUvLo,
  input  logic       overTempHi,
  input  logic       extLatchHi,
  input  logic       burstLowLo,
  input  logic       burstHighHi,
  output logic       ssDischarge,
  output logic       timerCharge,
  output logic       gateEn,
  output logic       latchedOff,
  output logic [2:0] fsmState
);
  logic [NUM_IN-1:0] rawVec, synVec;
  ctrlStrobe_t strobe;
  dpStatus_t   status;
  seqState_t   state;

  always_comb begin
    rawVec           = '0;
    rawVec[I_CSREG]  = csRegHi;
    rawVec[I_CSTRIP] = csTripHi;
    rawVec[I_TMID]   = tmrMidHi;
    rawVec[I_TTOP]   = tmrTopHi;
    rawVec[I_TLOW]   = tmrLowLo;
    rawVec[I_LON]    = lineOnHi;
    rawVec[I_LOFF]   = lineOffLo;
    rawVec[I_LOV]    = lineOvHi;
    rawVec[I_VSTART] = vccStartHi;
    rawVec[I_VUV]    = vccUvLo;
    rawVec[I_OT]     = overTempHi;
    rawVec[I_EXT]    = extLatchHi;
    rawVec[I_BLOW]   = burstLowLo;
    rawVec[I_BHIGH]  = burstHighHi;
  end

  ocp_sync_bits #(.WIDTH(NUM_IN), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .asyncIn(rawVec), .syncOut(synVec));

  ocp_seq_dp #(.HOLD_CYCLES(HOLD_CYCLES), .SS_CYCLES(SS_CYCLES)) u_dp (
    .clk(clk), .rst_n(rst_n), .syn(synVec), .strobe(strobe), .status(status));

  ocp_seq_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .status(status), .strobe(strobe), .state(state),
    .ssDischarge(ssDischarge), .timerCharge(timerCharge),
    .gateEn(gateEn), .latchedOff(latchedOff));

  assign fsmState = state;
endmodule

// File: tb/ocp_fault_seq_bench.sv
module ocp_fault_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD = 8;
  localparam int SSC  = 16;

  localparam logic [2:0] S_OFF = 3'd0, S_SS = 3'd1, S_RUN = 3'd2, S_OCR = 3'd3,
                         S_FMAX = 3'd4, S_BURST = 3'd5, S_LAT = 3'd6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic csRegHi = 0, csTripHi = 0, tmrMidHi = 0, tmrTopHi = 0, tmrLowLo = 0;
  logic lineOnHi = 0, lineOffLo = 0, lineOvHi = 0, vccStartHi = 0, vccUvLo = 0;
  logic overTempHi = 0, extLatchHi = 0, burstLowLo = 0, burstHighHi = 0;
  logic ssDischarge, timerCharge, gateEn, latchedOff;
  logic [2:0] fsmState;

  int checks = 0, errors = 0;
  bit finished = 0;

  typedef struct {
    logic [2:0] st;
    logic gate, ss, chg, lat;
    string tag;
  } expItem_t;
  expItem_t expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  ocp_fault_seq #(.HOLD_CYCLES(HOLD), .SS_CYCLES(SSC)) u_ocp_fault_seq (
    .clk(clk), .rst_n(rst_n), .csRegHi(csRegHi), .csTripHi(csTripHi),
    .tmrMidHi(tmrMidHi), .tmrTopHi(tmrTopHi), .tmrLowLo(tmrLowLo),
    .lineOnHi(lineOnHi), .lineOffLo(lineOffLo), .lineOvHi(lineOvHi),
    .vccStartHi(vccStartHi), .vccUvLo(vccUvLo), .overTempHi(overTempHi),
    .extLatchHi(extLatchHi), .burstLowLo(burstLowLo), .burstHighHi(burstHighHi),
    .ssDischarge(ssDischarge), .timerCharge(timerCharge), .gateEn(gateEn),
    .latchedOff(latchedOff), .fsmState(fsmState));

  // Monitor: compares queued expectations away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      if (expQ.size() > 0) begin
        expItem_t e;
        e = expQ.pop_front();
        checks++;
        if (fsmState !== e.st || gateEn !== e.gate || ssDischarge !== e.ss ||
            timerCharge !== e.chg || latchedOff !== e.lat) begin
          errors++;
          $display("FAIL %s: actual st=%0d gate=%b ss=%b chg=%b lat=%b expected st=%0d gate=%b ss=%b chg=%b lat=%b",
                   e.tag, fsmState, gateEn, ssDischarge, timerCharge, latchedOff,
                   e.st, e.gate, e.ss, e.chg, e.lat);
        end
      end
    end
  end

  // Expected outputs derived from the state code per requirement
  task automatic expectAfter(input int n, input logic [2:0] st, input string tag);
    expItem_t e;
    repeat (n) @(posedge clk);
    e.st   = st;
    e.gate = (st == S_SS || st == S_RUN || st == S_OCR || st == S_FMAX);
    e.ss   = (st == S_OFF || st == S_OCR || st == S_FMAX || st == S_LAT);
    e.chg  = (st == S_OCR || st == S_FMAX);
    e.lat  = (st == S_LAT);
    e.tag  = tag;
    expQ.push_back(e);
    wait (expQ.size() == 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    expectAfter(1, S_OFF, "R12 reset state");
    lineOnHi = 1; vccStartHi = 1;
    expectAfter(6, S_SS, "R11 soft start entry");
    expectAfter(20, S_RUN, "R11 soft start ends in run");
    csRegHi = 1;
    expectAfter(5, S_OCR, "R1 regulation entry");
    csRegHi = 0;
    expectAfter(3, S_OCR, "R1 minimum hold");
    expectAfter(15, S_RUN, "R2 regulation exit");
    burstLowLo = 1;
    expectAfter(5, S_BURST, "R9 burst idle");
    burstLowLo = 0;
    expectAfter(4, S_BURST, "R9 burst hysteresis hold");
    burstHighHi = 1;
    expectAfter(5, S_RUN, "R9 burst wake without soft start");
    burstHighHi = 0;
    csRegHi = 1;
    expectAfter(5, S_OCR, "R1 regulation again");
    tmrMidHi = 1;
    expectAfter(5, S_FMAX, "R3 forced max frequency");
    csRegHi = 0;
    expectAfter(5, S_SS, "R3 fmax recovery to soft start");
    tmrMidHi = 0;
    expectAfter(20, S_RUN, "R11 run after recovery");
    csRegHi = 1; tmrMidHi = 1;
    expectAfter(8, S_FMAX, "R3 fmax before stop");
    tmrTopHi = 1;
    expectAfter(5, S_LAT, "R4 timer top latches");
    csRegHi = 0; tmrMidHi = 0; tmrTopHi = 0; tmrLowLo = 1;
    expectAfter(6, S_LAT, "R6 timer low alone keeps latch");
    vccStartHi = 0; vccUvLo = 1;
    expectAfter(5, S_OFF, "R6 release after uv and timer low");
    vccUvLo = 0; tmrLowLo = 0;
    expectAfter(5, S_OFF, "R6 no restart without supply start");
    vccStartHi = 1;
    expectAfter(6, S_SS, "R6 restart via soft start");
    expectAfter(20, S_RUN, "R11 run");
    csTripHi = 1;
    expectAfter(5, S_LAT, "R5 trip latches");
    csTripHi = 0; vccStartHi = 0; vccUvLo = 1;
    expectAfter(6, S_LAT, "R6 uv alone keeps overcurrent latch");
    tmrLowLo = 1;
    expectAfter(5, S_OFF, "R6 release");
    vccUvLo = 0; tmrLowLo = 0; vccStartHi = 1;
    expectAfter(6, S_SS, "R10 restart");
    extLatchHi = 1;
    expectAfter(5, S_LAT, "R7 external latch");
    extLatchHi = 0;
    expectAfter(5, S_LAT, "R7 latch holds after input drops");
    vccStartHi = 0; vccUvLo = 1;
    expectAfter(5, S_OFF, "R7 uv alone releases external latch");
    vccUvLo = 0; vccStartHi = 1;
    expectAfter(6, S_SS, "R7 restart");
    lineOnHi = 0; lineOffLo = 1;
    expectAfter(5, S_OFF, "R8 brown-out");
    lineOffLo = 0;
    expectAfter(5, S_OFF, "R8 line hysteresis hold");
    lineOnHi = 1;
    expectAfter(6, S_SS, "R8 brown-in");
    lineOvHi = 1;
    expectAfter(5, S_OFF, "R8 line overvoltage");
    lineOvHi = 0;
    expectAfter(6, S_SS, "R8 recover");
    overTempHi = 1;
    expectAfter(5, S_OFF, "R10 over-temperature");
    overTempHi = 0;
    expectAfter(6, S_SS, "R10 recover");
    expectAfter(20, S_RUN, "R11 run");
    csTripHi = 1; lineOnHi = 0; lineOffLo = 1;
    expectAfter(5, S_LAT, "R13 latch beats line fault");
    csTripHi = 0; vccStartHi = 0; vccUvLo = 1; tmrLowLo = 1;
    expectAfter(5, S_OFF, "R13 release");
    lineOffLo = 0; lineOnHi = 1; vccUvLo = 0; tmrLowLo = 0; vccStartHi = 1;
    expectAfter(6, S_SS, "R13 restart");
    vccStartHi = 0; vccUvLo = 1; csTripHi = 1;
    expectAfter(5, S_OFF, "R13 uv beats trip");
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule